// File: doc/BRIEF.md
# Multi-Mode Pulse-Width Modulator with Sigma-Delta DAC

This peripheral sits on a byte-wide write bus and drives two output pins. An 8-bit control register picks one of eight operating modes, a clock source and a prescaler. Two 16-bit duty registers are written one byte at a time. Depending on the mode, the pins carry pulse-width modulated waveforms or first-order sigma-delta bit streams. In the sigma-delta modes an external RC filter turns a pin into a 16-bit DAC output.

A single 16-bit counter serves every mode. In the 16-bit modes the low byte is parked in a hidden holding register, and the high-byte write forms the full value. In every mode a newly written value waits in a pending buffer and only reaches the waveform at the next cycle boundary. When the control register's top bit is set, both pins are released so that other logic can use them.

Register addresses on `bus_addr`: 0 control, 1 duty A low, 2 duty A high, 3 duty B low, 4 duty B high.

Top module: `pwm_sd_dac`

## Requirements
- R1: After reset the control register reads as 0x00, both pins are driven (`pwm_oe` = 2'b11) and both outputs are low.
- R2: Control bit 7 set releases both pins: `pwm_oe` = 2'b00 and `pwm_out` = 2'b00, whatever the mode.
- R3: Control bits [1:0] pick the base clock. Code 0 gives one base tick every 15 system clocks. Codes 1 and 3 give a tick on every system clock. Code 2 gives a tick per rising edge of `ext_clk`, taken after a two-flop synchroniser.
- R4: Control bits [3:2] = 0,1,2,3 advance the counter once every 1, 4, 16 or 64 base ticks.
- R5: Any control write clears the counter, the prescaler, the sigma-delta accumulators and the sigma-delta output bits.
- R6: Mode 1 (bits [6:4] = 1): the counter runs from 0 to duty A and then wraps. Pin 0 is high while the counter is below duty B. Pin 1 is low.
- R7: Mode 2: the counter runs from 0 to duty A[15:8]. Pin n is high while count[7:0] is below the low byte of its own duty register.
- R8: Mode 3: the counter spans the full 16 bits. Pin n is high while the count is below its own 16-bit duty.
- R9: Mode 5: the counter spans 0 to 255. Pin n is high while count[7:0] is below the low byte of its own duty.
- R10: Mode 4: on every counter step each channel adds its duty to a 16-bit accumulator. The pin shows the carry of the last addition.
- R11: Mode 6: each bit slot lasts two counter steps. The accumulator advances when an odd count ends. The carry is shown during the even count and the pin is low during the odd count.
- R12: In modes 1, 3, 4 and 6 a low-byte write only fills a hidden holding byte. The high-byte write queues {high, held low} as one value. In the other modes each byte write updates its byte of the queued value directly.
- R13: A queued value reaches the waveform only when the counter wraps (PWM modes), at each accumulator step (sigma-delta modes), or on the next clock (modes 0 and 7).
- R14: Modes 0 and 7 hold both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| pwm_out | output | 2 | Pin output values |
| pwm_oe | output | 2 | Pin drive enables |

## Verification
Most internal faults in this block show up on a pin within one period, or within one accumulator step. A wrong counter, prescale or clock-select state moves the first pin transition after a control write, and that delay can be measured to the exact cycle. A buffering fault makes a new duty appear mid-period, or never appear, so the pulse width measured after a wrap is off. Accumulator faults change the density of ones over a short window. The bench therefore measures pulse widths and counts ones over fixed windows, and it also compares every pin against a cycle model on every clock.

// File: rtl/pwm_sd_dac.sv
module pwm_sd_dac #(
  parameter int OSC_DIV = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [1:0] pwm_out,
  output logic [1:0] pwm_oe
);
  localparam int PW = $clog2(OSC_DIV);

  logic [7:0]       ctrl;
  logic [2:0]       xs;
  logic [PW-1:0]    p15;
  logic [5:0]       pre, lim;
  logic [15:0]      cnt, last;
  logic [1:0][15:0] act, pend, acc;
  logic [1:0][7:0]  hold;
  logic [1:0]       pv, sd, raw, lo_wr, hi_wr;
  logic [1:0][16:0] sum;
  logic             base_tick, cnt_tick, wrap, is16, idle, sd_step, commit;

  wire       dis  = ctrl[7];
  wire [2:0] mode = ctrl[6:4];
  wire [1:0] cdiv = ctrl[3:2];
  wire [1:0] csel = ctrl[1:0];
  wire       wr_ctrl = bus_we && bus_addr == 3'd0;

  always_comb begin
    case (csel)
      2'd0:    base_tick = p15 == PW'(OSC_DIV - 1);
      2'd2:    base_tick = xs[1] & ~xs[2];
      default: base_tick = 1'b1;
    endcase
    case (cdiv)
      2'd0:    lim = 6'd0;
      2'd1:    lim = 6'd3;
      2'd2:    lim = 6'd15;
      default: lim = 6'd63;
    endcase
    case (mode)
      3'd1:    last = act[0];
      3'd2:    last = {8'd0, act[0][15:8]};
      3'd5:    last = 16'd255;
      default: last = 16'hFFFF;
    endcase
  end

  assign cnt_tick = !wr_ctrl && base_tick && pre == lim;
  assign wrap     = cnt >= last;
  assign is16     = mode == 3'd1 || mode == 3'd3 || mode == 3'd4 || mode == 3'd6;
  assign idle     = mode == 3'd0 || mode == 3'd7;
  assign sd_step  = cnt_tick && (mode == 3'd4 || (mode == 3'd6 && cnt[0]));
  assign commit   = idle || sd_step ||
                    (cnt_tick && wrap && mode != 3'd4 && mode != 3'd6);

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign lo_wr[i] = bus_we && bus_addr == 3'(2 * i + 1);
    assign hi_wr[i] = bus_we && bus_addr == 3'(2 * i + 2);
    assign sum[i]   = {1'b0, acc[i]} + {1'b0, act[i]};

    always_comb begin
      case (mode)
        3'd1:       raw[i] = (i == 0) ? (cnt < act[1]) : 1'b0;
        3'd2, 3'd5: raw[i] = cnt[7:0] < act[i][7:0];
        3'd3:       raw[i] = cnt < act[i];
        3'd4:       raw[i] = sd[i];
        3'd6:       raw[i] = sd[i] & ~cnt[0];
        default:    raw[i] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act[i]  <= '0;
        pend[i] <= '0;
        hold[i] <= '0;
        pv[i]   <= 1'b0;
        acc[i]  <= '0;
        sd[i]   <= 1'b0;
      end else begin
        if (wr_ctrl) begin
          acc[i] <= '0;
          sd[i]  <= 1'b0;
        end else if (sd_step) begin
          acc[i] <= sum[i][15:0];
          sd[i]  <= sum[i][16];
        end
        if (commit && pv[i]) begin
          act[i] <= pend[i];
          pv[i]  <= 1'b0;
        end
        if (lo_wr[i]) begin
          if (is16) hold[i] <= bus_wdata;
          else begin
            pend[i][7:0] <= bus_wdata;
            pv[i]        <= 1'b1;
          end
        end
        if (hi_wr[i]) begin
          pend[i] <= is16 ? {bus_wdata, hold[i]} : {bus_wdata, pend[i][7:0]};
          pv[i]   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      xs   <= '0;
      p15  <= '0;
      pre  <= '0;
      cnt  <= '0;
    end else begin
      xs <= {xs[1:0], ext_clk};
      if (wr_ctrl) begin
        ctrl <= bus_wdata;
        p15  <= '0;
        pre  <= '0;
        cnt  <= '0;
      end else begin
        p15 <= (p15 == PW'(OSC_DIV - 1)) ? '0 : p15 + 1'b1;
        if (base_tick) pre <= (pre == lim) ? 6'd0 : pre + 6'd1;
        if (cnt_tick)  cnt <= wrap ? 16'd0 : cnt + 16'd1;
      end
    end
  end

  assign pwm_oe  = dis ? 2'b00 : 2'b11;
  assign pwm_out = dis ? 2'b00 : raw;
endmodule

// File: rtl/pwm_sd_dac_chk.sv
module pwm_sd_dac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctrl,
  input logic [15:0] cnt,
  input logic [15:0] act0,
  input logic [15:0] pend0,
  input logic [5:0]  pre,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [1:0]  pwm_out,
  input logic [1:0]  pwm_oe
);
  wire [2:0] md = ctrl[6:4];
  wire m16 = md == 3'd1 || md == 3'd3 || md == 3'd4 || md == 3'd6;
  wire pwm_md = md == 3'd1 || md == 3'd2 || md == 3'd3 || md == 3'd5;

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |-> (pwm_oe == 2'b00 && pwm_out == 2'b00));

  p_count_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0) |=> cnt == 16'd0);

  p_prescale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:2] == 2'd0) |-> pre == 6'd0);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1 && m16) |=> $stable(pend0));

  p_boundary_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_md && $stable(ctrl) && !$stable(act0)) |-> cnt == 16'd0);

  p_idle_low_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 3'd0 || md == 3'd7) |-> pwm_out == 2'b00);
endmodule

bind pwm_sd_dac pwm_sd_dac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cnt(cnt), .act0(act[0]),
  .pend0(pend[0]), .pre(pre), .bus_we(bus_we), .bus_addr(bus_addr),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/tb_pwm_sd_dac.sv
module tb_pwm_sd_dac;
  logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] pwm_out, pwm_oe;
  int n_chk = 0, n_err = 0, ext_ctr = 0;
  string cur_req = "R14";

  always #5 clk = ~clk;

  pwm_sd_dac dut (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  always @(negedge clk) begin
    ext_ctr <= ext_ctr + 1;
    ext_clk <= ext_ctr[1];
  end

  // reference cycle model built from the requirements
  logic [7:0]  m_ctrl;
  logic [2:0]  m_xs;
  int          m_osc, m_pre;
  logic [15:0] m_cnt;
  logic [15:0] m_act [2], m_pend [2], m_acc [2];
  logic [7:0]  m_hold [2];
  logic        m_pv [2];
  logic [1:0]  m_sd;
  logic [2:0]  m_md;
  logic        m_wrc, m_base, m_tick, m_step, m_com, m_16;
  int          m_div;
  logic [15:0] m_top;
  logic [1:0]  e_out, e_oe;

  always_comb begin
    m_md  = m_ctrl[6:4];
    m_wrc = bus_we && bus_addr == 3'd0;
    m_div = 1 << (2 * int'(m_ctrl[3:2]));
    case (m_ctrl[1:0])
      2'd0: m_base = (m_osc == 14);
      2'd2: m_base = m_xs[1] && !m_xs[2];
      default: m_base = 1'b1;
    endcase
    m_tick = !m_wrc && m_base && (m_pre == m_div - 1);
    m_top = (m_md == 3'd1) ? m_act[0] : (m_md == 3'd2) ? {8'd0, m_act[0][15:8]} :
            (m_md == 3'd5) ? 16'd255 : 16'hFFFF;
    m_16  = m_md inside {3'd1, 3'd3, 3'd4, 3'd6};
    m_step = m_tick && (m_md == 3'd4 || (m_md == 3'd6 && m_cnt[0]));
    m_com = (m_md == 3'd0 || m_md == 3'd7) || m_step ||
            (m_tick && m_cnt >= m_top && m_md != 3'd4 && m_md != 3'd6);
    case (m_md)
      3'd1: e_out = {1'b0, m_cnt < m_act[1]};
      3'd2, 3'd5: e_out = {m_cnt[7:0] < m_act[1][7:0], m_cnt[7:0] < m_act[0][7:0]};
      3'd3: e_out = {m_cnt < m_act[1], m_cnt < m_act[0]};
      3'd4: e_out = m_sd;
      3'd6: e_out = m_cnt[0] ? 2'b00 : m_sd;
      default: e_out = 2'b00;
    endcase
    e_oe = 2'b11;
    if (m_ctrl[7]) begin e_out = 2'b00; e_oe = 2'b00; end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_xs <= '0; m_osc <= 0; m_pre <= 0; m_cnt <= '0; m_sd <= '0;
      for (int c = 0; c < 2; c++) begin
        m_act[c] <= '0; m_pend[c] <= '0; m_acc[c] <= '0; m_hold[c] <= '0; m_pv[c] <= 1'b0;
      end
    end else begin
      m_xs <= {m_xs[1:0], ext_clk};
      if (m_wrc) begin
        m_ctrl <= bus_wdata; m_osc <= 0; m_pre <= 0; m_cnt <= '0; m_sd <= '0;
        m_acc[0] <= '0; m_acc[1] <= '0;
      end else begin
        m_osc <= (m_osc + 1) % 15;
        if (m_base) m_pre <= (m_pre + 1) % m_div;
        if (m_tick) m_cnt <= (m_cnt >= m_top) ? 16'd0 : m_cnt + 16'd1;
        if (m_step) for (int c = 0; c < 2; c++) begin
          m_acc[c] <= m_acc[c] + m_act[c];
          m_sd[c]  <= (32'(m_acc[c]) + 32'(m_act[c])) > 32'hFFFF;
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (m_com && m_pv[c]) begin m_act[c] <= m_pend[c]; m_pv[c] <= 1'b0; end
        if (bus_we && bus_addr == 3'(2 * c + 1)) begin
          if (m_16) m_hold[c] <= bus_wdata;
          else begin m_pend[c][7:0] <= bus_wdata; m_pv[c] <= 1'b1; end
        end
        if (bus_we && bus_addr == 3'(2 * c + 2)) begin
          m_pend[c] <= {bus_wdata, m_16 ? m_hold[c] : m_pend[c][7:0]};
          m_pv[c] <= 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n) check({pwm_oe, pwm_out} == {e_oe, e_out},
                     m_ctrl[7] ? "R2" : cur_req, int'({pwm_oe, pwm_out}), int'({e_oe, e_out}));

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    wr(3'd0, 8'h00);
    wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, b[7:0]); wr(3'd4, b[15:8]);
    @(negedge clk);
  endtask

  task automatic high_run(input int ch, output int n);
    n = 0;
    while (pwm_out[ch]) begin n++; @(negedge clk); end
  endtask

  task automatic meas(input int ch, output int n);
    while (pwm_out[ch]) @(negedge clk);
    while (!pwm_out[ch]) @(negedge clk);
    high_run(ch, n);
  endtask

  task automatic ones(input int ch, output int n);
    n = 0;
    for (int k = 0; k < 64; k++) begin n += int'(pwm_out[ch]); @(negedge clk); end
  endtask

  function automatic string mreq(input int m);
    case (m)
      1: return "R6"; 2: return "R7"; 3: return "R8"; 4: return "R10";
      5: return "R9"; 6: return "R11"; default: return "R14";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n, m, ch;
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 2'b00 && pwm_oe == 2'b11, "R1", int'({pwm_oe, pwm_out}), 12);

    // R3 / R4: time to the first high->low transition after a control write
    load(16'd9, 16'd2);
    cur_req = "R6";
    wr(3'd0, {4'b0001, 2'd1, 2'd1}); high_run(0, n); check(n == 8,   "R4", n, 8);
    wr(3'd0, {4'b0001, 2'd1, 2'd0}); high_run(0, n); check(n == 120, "R3", n, 120);
    wr(3'd0, {4'b0001, 2'd0, 2'd3}); high_run(0, n); check(n == 2,   "R3", n, 2);
    wr(3'd0, {4'b0001, 2'd2, 2'd1}); high_run(0, n); check(n == 32,  "R4", n, 32);
    wr(3'd0, {4'b0001, 2'd0, 2'd2}); high_run(0, n); check(n >= 5 && n <= 8, "R3", n, 8);

    // R5: rewriting control restarts the period
    wr(3'd0, 8'h13); repeat (3) @(negedge clk);
    check(pwm_out[0] == 1'b0, "R6", int'(pwm_out[0]), 0);
    wr(3'd0, 8'h13);
    check(pwm_out[0] == 1'b1, "R5", int'(pwm_out[0]), 1);

    // R12 / R13: 16-bit loading order and boundary commit
    wr(3'd3, 8'd7);
    repeat (12) @(negedge clk);
    meas(0, n); check(n == 2, "R12", n, 2);
    while (pwm_out[0]) @(negedge clk);
    @(negedge clk);
    wr(3'd4, 8'd0);
    check(pwm_out[0] == 1'b0, "R13", int'(pwm_out[0]), 0);
    meas(0, n); check(n == 7, "R13", n, 7);

    // R9 / R12: 8-bit mode, single byte write takes effect directly at wrap
    load(16'h0020, 16'h0010);
    cur_req = "R9";
    wr(3'd0, 8'h53);
    repeat (40) @(negedge clk);
    wr(3'd1, 8'h50);
    meas(0, n); check(n == 80, "R12", n, 80);

    // R7
    load({8'd19, 8'd5}, 16'd12);
    cur_req = "R7";
    wr(3'd0, 8'h23);
    meas(0, n); check(n == 5, "R7", n, 5);
    meas(1, n); check(n == 12, "R7", n, 12);

    // R8
    load(16'h0030, 16'h0100);
    cur_req = "R8";
    wr(3'd0, 8'h33);
    high_run(0, n); check(n == 48, "R8", n, 48);
    high_run(1, n); check(n == 256 - 48, "R8", n, 208);

    // R10 / R11
    load(16'h8000, 16'h4000);
    cur_req = "R10";
    fork begin wr(3'd0, 8'h43); end join
    fork ones(0, n); ones(1, m); join
    check(n == 31, "R10", n, 31); check(m == 15, "R10", m, 15);
    cur_req = "R11";
    wr(3'd0, 8'h63);
    fork ones(0, n); ones(1, m); join
    check(n == 15, "R11", n, 15); check(m == 7, "R11", m, 7);

    // R14 / R2
    load(16'hFFFF, 16'hFFFF);
    cur_req = "R14";
    wr(3'd0, 8'h73); repeat (20) @(negedge clk);
    check(pwm_out == 2'b00, "R14", int'(pwm_out), 0);
    wr(3'd0, 8'hB3); repeat (5) @(negedge clk);
    check(pwm_oe == 2'b00 && pwm_out == 2'b00, "R2", int'({pwm_oe, pwm_out}), 0);

    // constrained random phases against the cycle model
    for (int ph = 0; ph < 24; ph++) begin
      m = ph % 8;
      cur_req = mreq(m);
      wr(3'd0, {($urandom % 6 == 0) ? 1'b1 : 1'b0, 3'(m), 2'($urandom % 3), 2'($urandom)});
      for (int r = 1; r <= 4; r++) wr(3'(r), (r % 2 == 0) ? 8'($urandom % 3) : 8'($urandom));
      for (int cyc = 0; cyc < 1200; cyc++) begin
        if ($urandom % 64 == 0) begin
          ch = 1 + int'($urandom % 4);
          d = (ch % 2 == 0) ? 8'($urandom % 3) : 8'($urandom);
          wr(3'(ch), d);
        end else @(negedge clk);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule